// File: doc/BRIEF.md
# Selection-with-Attention Command Sequencer

This block runs one high-level initiator command on a parallel SCSI-style bus. On a select-with-attention command it arbitrates, selects a target with ATN asserted, and sends three message bytes: an identify byte followed by a two-byte queue tag. It then sends a command descriptor of programmable length. Every byte comes from a local show-ahead FIFO, and each transfer is a REQ/ACK handshake that is checked against the target's phase lines first.

The sequence can finish or stop at several defined points. At each one the block records a 3-bit sequence-step code and an 8-bit interrupt status. Both are held until software reads them. The block also rejects initiator-group commands that arrive while it is not connected as an initiator. It detects loss of BSY through a synchronizer and reports the disconnect.

Top module: `satn_sequencer`

## Requirements
- R1: After reset, bsy_out, sel_out, atn_out, ack_out and irq_out are low, and irq_status, seq_step and cmd_reg are zero.
- R2: Command code 0x46 in the idle state is accepted and held in cmd_reg. The block arbitrates with bsy_out, then raises sel_out together with atn_out. Each byte is read from the FIFO in order: fifo_rd is asserted only while REQ is seen, and ack_out follows one cycle later with that byte on data_out.
- R3: If three bytes are taken in message-out phase (phase_in = 110) and then cdb_len bytes in command phase (phase_in = 010), the sequence ends with status 0x18 and step 100. atn_out is already low when the third message byte is acknowledged.
- R4: If the target does not raise BSY within the loaded timeout count after sel_out rises, the block reports status 0x20 and step 000, and it releases SEL and ATN.
- R5: If the first REQ after selection is not in message-out phase, the block stops with status 0x18 and step 000 and keeps atn_out high.
- R6: If the target leaves message-out after one or two bytes, the block stops with status 0x18 and step 010 and keeps atn_out high.
- R7: If the first REQ after the third message byte is not in command phase, the block stops with status 0x18 and step 010, and atn_out is low.
- R8: A phase change in the middle of the command bytes stops the block with status 0x18 and step 011. Bytes that were not sent stay in the FIFO.
- R9: An initiator-group command (codes 0x10 to 0x1F) that arrives while the block is not connected is ignored on the bus. It raises status 0x40 and clears cmd_reg to zero. While connected, code 0x1B is accepted into cmd_reg and lowers atn_out, with no interrupt.
- R10: If bsy_in goes low while the block is connected, irq_out rises on the third rising edge after the change, with status 0x20 and step 000. ATN is released.
- R11: Status and step stay unchanged until irq_rd is pulsed. The read clears both to zero and drops irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 8 | Command code |
| cmd_cdb_len | input | LEN_W | Command descriptor byte count, loaded with a select |
| cmd_sel_tmo | input | TMO_W | Selection timeout in cycles, loaded with a select |
| cmd_reg | output | 8 | Last accepted command code |
| fifo_rd | output | 1 | Pops one byte from the FIFO |
| fifo_data | input | DATA_W | Byte at the FIFO head |
| bsy_in | input | 1 | Target BSY line (asynchronous) |
| req_in | input | 1 | Target REQ |
| phase_in | input | 3 | Target phase lines (MSG, C/D, I/O) |
| bsy_out | output | 1 | Own BSY during arbitration |
| sel_out | output | 1 | SEL line |
| atn_out | output | 1 | ATN line |
| ack_out | output | 1 | ACK line |
| data_out | output | DATA_W | Data bus driven during ACK |
| irq_rd | input | 1 | Interrupt register read strobe |
| irq_out | output | 1 | Interrupt request |
| irq_status | output | 8 | Interrupt status bits |
| seq_step | output | 3 | Sequence-step code |

## Verification
The assertions assume the following about the inputs. req_in and phase_in are synchronous to clk. phase_in is stable whenever req_in is high. The target drops REQ only after it has seen ACK. The FIFO already holds every byte that the sequence may take, because the block never checks for an empty FIFO. The stimulus changes inputs only on falling edges. It loads the FIFO and flushes it before each command, and it models the target as a handshake that waits for each ACK edge before moving REQ.

// File: rtl/satn_pkg.sv
package satn_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ARB, ST_SELECT, ST_WREQ, ST_ACKH, ST_CONN
   } seq_st_t;

   localparam logic [7:0] CMD_SEL_ATN3 = 8'h46;
   localparam logic [7:0] CMD_GRP_MASK = 8'hF0;
   localparam logic [7:0] CMD_GRP_INIT = 8'h10;
   localparam logic [7:0] CMD_DROP_ATN = 8'h1B;

   localparam logic [2:0] PH_MSG_OUT = 3'b110;
   localparam logic [2:0] PH_COMMAND = 3'b010;

   localparam logic [2:0] STEP_NONE = 3'b000;
   localparam logic [2:0] STEP_MSG  = 3'b010;
   localparam logic [2:0] STEP_CDB  = 3'b011;
   localparam logic [2:0] STEP_DONE = 3'b100;

   localparam logic [7:0] IRQ_DISC    = 8'h20;
   localparam logic [7:0] IRQ_SVC     = 8'h18;
   localparam logic [7:0] IRQ_ILLEGAL = 8'h40;

   localparam int MSG_BYTES = 3;
endpackage

// File: rtl/satn_sync.sv
module satn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad
      $error("satn_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
   end
endmodule

// File: rtl/satn_sel_timer.sv
module satn_sel_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt != limit)   cnt <= cnt + TMO_W'(1);
   end

   assign expired = run && (cnt == limit);
endmodule

// File: rtl/satn_irq_hold.sv
module satn_irq_hold #(
   parameter int STAT_W = 8,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] ev_bits,
   input  logic              ev_ld_step,
   input  logic [STEP_W-1:0] ev_step,
   input  logic              rd,
   output logic [STAT_W-1:0] status,
   output logic [STEP_W-1:0] step,
   output logic              irq
);
   logic [STAT_W-1:0] stat_n;
   logic [STEP_W-1:0] step_n;

   always_comb begin
      stat_n = rd ? '0 : status;
      step_n = rd ? '0 : step;
      stat_n = stat_n | ev_bits;
      if (ev_ld_step) step_n = ev_step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         step   <= '0;
      end else begin
         status <= stat_n;
         step   <= step_n;
      end
   end

   assign irq = |status;
endmodule

// File: rtl/satn_sequencer.sv
module satn_sequencer
   import satn_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LEN_W       = 4,
   parameter int TMO_W       = 16,
   parameter int ARB_CYC     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic [LEN_W-1:0]  cmd_cdb_len,
   input  logic [TMO_W-1:0]  cmd_sel_tmo,
   output logic [7:0]        cmd_reg,
   output logic              fifo_rd,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              bsy_in,
   input  logic              req_in,
   input  logic [2:0]        phase_in,
   output logic              bsy_out,
   output logic              sel_out,
   output logic              atn_out,
   output logic              ack_out,
   output logic [DATA_W-1:0] data_out,
   input  logic              irq_rd,
   output logic              irq_out,
   output logic [7:0]        irq_status,
   output logic [2:0]        seq_step
);
   localparam int ARB_CW = (ARB_CYC < 2) ? 1 : $clog2(ARB_CYC + 1);
   localparam logic [ARB_CW-1:0] ARB_LAST = ARB_CW'(ARB_CYC - 1);
   localparam logic [1:0] MSG_LAST = 2'(MSG_BYTES - 1);
   localparam logic [1:0] MSG_ALL  = 2'(MSG_BYTES);

   if (DATA_W < 8) begin : g_bad_data
      $error("satn_sequencer: DATA_W must be at least 8");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("satn_sequencer: LEN_W out of range");
   end
   if (TMO_W < 2) begin : g_bad_tmo
      $error("satn_sequencer: TMO_W too small");
   end
   if (ARB_CYC < 1) begin : g_bad_arb
      $error("satn_sequencer: ARB_CYC must be at least 1");
   end

   seq_st_t            st, st_n;
   logic [ARB_CW-1:0]  arb_cnt, arb_n;
   logic [1:0]         msg_cnt, msg_n;
   logic [LEN_W-1:0]   cdb_cnt, cdb_n, len_q, len_n;
   logic [TMO_W-1:0]   tmo_q, tmo_n;
   logic               atn_q, atn_n, ack_q, ack_n;
   logic [DATA_W-1:0]  dat_q, dat_n;
   logic [7:0]         cmd_q, cmd_n;
   logic               rd_c;
   logic [7:0]         ev_bits;
   logic               ev_ld;
   logic [2:0]         ev_step;
   logic               bsy_s, tmo_hit, is_grp;

   satn_sync #(.STAGES(SYNC_STAGES)) u_bsy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bsy_in),
      .q     (bsy_s)
   );

   satn_sel_timer #(.TMO_W(TMO_W)) u_sel_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == ST_SELECT),
      .limit   (tmo_q),
      .expired (tmo_hit)
   );

   satn_irq_hold #(.STAT_W(8), .STEP_W(3)) u_irq_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_bits    (ev_bits),
      .ev_ld_step (ev_ld),
      .ev_step    (ev_step),
      .rd         (irq_rd),
      .status     (irq_status),
      .step       (seq_step),
      .irq        (irq_out)
   );

   assign is_grp = (cmd_code & CMD_GRP_MASK) == CMD_GRP_INIT;

   always_comb begin
      st_n    = st;
      arb_n   = arb_cnt;
      msg_n   = msg_cnt;
      cdb_n   = cdb_cnt;
      len_n   = len_q;
      tmo_n   = tmo_q;
      atn_n   = atn_q;
      ack_n   = ack_q;
      dat_n   = dat_q;
      cmd_n   = cmd_q;
      rd_c    = 1'b0;
      ev_bits = '0;
      ev_ld   = 1'b0;
      ev_step = STEP_NONE;

      // initiator-group command outside the connected state
      if (cmd_valid && is_grp && st != ST_CONN) begin
         ev_bits = ev_bits | IRQ_ILLEGAL;
         cmd_n   = '0;
      end

      unique case (st)
         ST_IDLE: begin
            atn_n = 1'b0;
            if (cmd_valid && cmd_code == CMD_SEL_ATN3) begin
               st_n  = ST_ARB;
               arb_n = '0;
               msg_n = '0;
               cdb_n = '0;
               len_n = cmd_cdb_len;
               tmo_n = cmd_sel_tmo;
               cmd_n = cmd_code;
            end
         end
         ST_ARB: begin
            if (bsy_s) begin
               arb_n = '0;
            end else if (arb_cnt == ARB_LAST) begin
               st_n  = ST_SELECT;
               atn_n = 1'b1;
            end else begin
               arb_n = arb_cnt + ARB_CW'(1);
            end
         end
         ST_SELECT: begin
            if (bsy_s) begin
               st_n = ST_WREQ;
            end else if (tmo_hit) begin
               st_n    = ST_IDLE;
               atn_n   = 1'b0;
               ev_bits = ev_bits | IRQ_DISC;
               ev_ld   = 1'b1;
               ev_step = STEP_NONE;
            end
         end
         ST_WREQ: begin
            if (!bsy_s) begin
               st_n    = ST_IDLE;
               atn_n   = 1'b0;
               ack_n   = 1'b0;
               ev_bits = ev_bits | IRQ_DISC;
               ev_ld   = 1'b1;
               ev_step = STEP_NONE;
            end else if (req_in) begin
               if (msg_cnt != MSG_ALL) begin
                  if (phase_in == PH_MSG_OUT) begin
                     rd_c  = 1'b1;
                     dat_n = fifo_data;
                     ack_n = 1'b1;
                     msg_n = msg_cnt + 2'd1;
                     if (msg_cnt == MSG_LAST) atn_n = 1'b0;
                     st_n  = ST_ACKH;
                  end else begin
                     st_n    = ST_CONN;
                     ev_bits = ev_bits | IRQ_SVC;
                     ev_ld   = 1'b1;
                     ev_step = (msg_cnt == 2'd0) ? STEP_NONE : STEP_MSG;
                  end
               end else if (phase_in == PH_COMMAND && cdb_cnt != len_q) begin
                  rd_c  = 1'b1;
                  dat_n = fifo_data;
                  ack_n = 1'b1;
                  cdb_n = cdb_cnt + LEN_W'(1);
                  st_n  = ST_ACKH;
               end else begin
                  st_n    = ST_CONN;
                  ev_bits = ev_bits | IRQ_SVC;
                  ev_ld   = 1'b1;
                  ev_step = (cdb_cnt == '0) ? STEP_MSG : STEP_CDB;
               end
            end
         end
         ST_ACKH: begin
            if (!bsy_s) begin
               st_n    = ST_IDLE;
               atn_n   = 1'b0;
               ack_n   = 1'b0;
               ev_bits = ev_bits | IRQ_DISC;
               ev_ld   = 1'b1;
               ev_step = STEP_NONE;
            end else if (!req_in) begin
               ack_n = 1'b0;
               if (msg_cnt == MSG_ALL && cdb_cnt == len_q) begin
                  st_n    = ST_CONN;
                  ev_bits = ev_bits | IRQ_SVC;
                  ev_ld   = 1'b1;
                  ev_step = STEP_DONE;
               end else begin
                  st_n = ST_WREQ;
               end
            end
         end
         ST_CONN: begin
            if (!bsy_s) begin
               st_n    = ST_IDLE;
               atn_n   = 1'b0;
               ev_bits = ev_bits | IRQ_DISC;
               ev_ld   = 1'b1;
               ev_step = STEP_NONE;
            end else if (cmd_valid && is_grp) begin
               cmd_n = cmd_code;
               if (cmd_code == CMD_DROP_ATN) atn_n = 1'b0;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         arb_cnt <= '0;
         msg_cnt <= '0;
         cdb_cnt <= '0;
         len_q   <= '0;
         tmo_q   <= '0;
         atn_q   <= 1'b0;
         ack_q   <= 1'b0;
         dat_q   <= '0;
         cmd_q   <= '0;
      end else begin
         st      <= st_n;
         arb_cnt <= arb_n;
         msg_cnt <= msg_n;
         cdb_cnt <= cdb_n;
         len_q   <= len_n;
         tmo_q   <= tmo_n;
         atn_q   <= atn_n;
         ack_q   <= ack_n;
         dat_q   <= dat_n;
         cmd_q   <= cmd_n;
      end
   end

   assign bsy_out  = (st == ST_ARB);
   assign sel_out  = (st == ST_SELECT);
   assign atn_out  = atn_q;
   assign ack_out  = ack_q;
   assign data_out = dat_q;
   assign fifo_rd  = rd_c;
   assign cmd_reg  = cmd_q;
endmodule

// File: rtl/satn_sequencer_chk.sv
module satn_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_out,
   input logic       atn_out,
   input logic       ack_out,
   input logic       req_in,
   input logic       fifo_rd,
   input logic       irq_out,
   input logic       irq_rd,
   input logic [2:0] seq_step
);
   AST_SEL_WITH_ATN: assert property (@(posedge clk) disable iff (!rst_n)
      sel_out |-> atn_out); // R2
   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_out) |-> $past(req_in)); // R2
   AST_POP_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> ack_out); // R2
   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !irq_rd) |=> irq_out); // R11
   AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (seq_step inside {3'b000, 3'b010, 3'b011, 3'b100})); // R3
endmodule

bind satn_sequencer satn_sequencer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_out  (sel_out),
   .atn_out  (atn_out),
   .ack_out  (ack_out),
   .req_in   (req_in),
   .fifo_rd  (fifo_rd),
   .irq_out  (irq_out),
   .irq_rd   (irq_rd),
   .seq_step (seq_step)
);

// File: tb/satn_sequencer_tb.sv
module satn_sequencer_tb;
   localparam int LEN_W = 4;
   localparam int TMO_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [7:0]       cmd_code = '0;
   logic [LEN_W-1:0] cmd_cdb_len = '0;
   logic [TMO_W-1:0] cmd_sel_tmo = '0;
   logic [7:0]       cmd_reg;
   logic             fifo_rd;
   logic [7:0]       fifo_data;
   logic             bsy_in = 1'b0;
   logic             req_in = 1'b0;
   logic [2:0]       phase_in = '0;
   logic             bsy_out, sel_out, atn_out, ack_out;
   logic [7:0]       data_out;
   logic             irq_rd = 1'b0;
   logic             irq_out;
   logic [7:0]       irq_status;
   logic [2:0]       seq_step;

   always #2 clk = ~clk;

   satn_sequencer #(.LEN_W(LEN_W), .TMO_W(TMO_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_cdb_len(cmd_cdb_len), .cmd_sel_tmo(cmd_sel_tmo), .cmd_reg(cmd_reg),
      .fifo_rd(fifo_rd), .fifo_data(fifo_data), .bsy_in(bsy_in),
      .req_in(req_in), .phase_in(phase_in), .bsy_out(bsy_out),
      .sel_out(sel_out), .atn_out(atn_out), .ack_out(ack_out),
      .data_out(data_out), .irq_rd(irq_rd), .irq_out(irq_out),
      .irq_status(irq_status), .seq_step(seq_step)
   );

   // FIFO model
   logic [7:0] fmem [32];
   int         wp = 0;
   int         rp = 0;
   logic       flush_req = 1'b0;
   assign fifo_data = fmem[rp[4:0]];
   always @(posedge clk) begin
      if (flush_req)    rp <= wp;
      else if (fifo_rd) rp <= rp + 1;
   end

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard queues
   logic [7:0]  exp_bytes [$];
   string       exp_btag  [$];
   logic [10:0] exp_irq   [$];
   string       exp_itag  [$];
   logic        ack_prev = 1'b0;
   logic        irq_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ack_out && !ack_prev) begin
            if (exp_bytes.size() == 0) chk("R2 unexpected byte", {24'd0, data_out}, 32'hFFFF);
            else chk(exp_btag.pop_front(), {24'd0, data_out}, {24'd0, exp_bytes.pop_front()});
         end
         if (irq_out && !irq_prev) begin
            if (exp_irq.size() == 0) chk("R11 unexpected irq", {21'd0, irq_status, seq_step}, 32'hFFFF);
            else chk(exp_itag.pop_front(), {21'd0, irq_status, seq_step}, {21'd0, exp_irq.pop_front()});
         end
      end
      ack_prev = ack_out;
      irq_prev = irq_out;
   end

   task automatic push_fifo(logic [7:0] b);
      fmem[wp[4:0]] = b;
      wp++;
   endtask

   task automatic flush();
      @(negedge clk) flush_req = 1'b1;
      @(negedge clk) flush_req = 1'b0;
   endtask

   task automatic expect_irq(logic [7:0] st, logic [2:0] sp, string tag);
      exp_irq.push_back({st, sp});
      exp_itag.push_back(tag);
   endtask

   task automatic issue(logic [7:0] code, int len, int tmo);
      @(negedge clk);
      cmd_code    = code;
      cmd_cdb_len = LEN_W'(len);
      cmd_sel_tmo = TMO_W'(tmo);
      cmd_valid   = 1'b1;
      @(negedge clk) cmd_valid = 1'b0;
   endtask

   task automatic wait_irq();
      for (int i = 0; i < 2000 && !irq_out; i++) @(negedge clk);
   endtask

   task automatic sw_read();
      irq_rd = 1'b1;
      @(negedge clk) irq_rd = 1'b0;
   endtask

   task automatic select_target();
      for (int i = 0; i < 2000 && !sel_out; i++) @(negedge clk);
      chk("R2 atn with sel", {31'd0, atn_out}, 32'd1);
      bsy_in = 1'b1;
   endtask

   task automatic xfer(logic [2:0] ph, logic [7:0] b, logic exp_atn, string tag);
      exp_bytes.push_back(b);
      exp_btag.push_back(tag);
      phase_in = ph;
      req_in   = 1'b1;
      for (int i = 0; i < 2000 && !ack_out; i++) @(negedge clk);
      chk({tag, " atn"}, {31'd0, atn_out}, {31'd0, exp_atn});
      req_in = 1'b0;
      for (int i = 0; i < 2000 && ack_out; i++) @(negedge clk);
   endtask

   task automatic stop_phase(logic [2:0] ph);
      phase_in = ph;
      req_in   = 1'b1;
      wait_irq();
      req_in = 1'b0;
   endtask

   task automatic disconnect();
      expect_irq(8'h20, 3'b000, "R10 disconnect status");
      @(negedge clk) bsy_in = 1'b0;
      @(negedge clk) chk("R10 irq early 1", {31'd0, irq_out}, 32'd0);
      @(negedge clk) chk("R10 irq early 2", {31'd0, irq_out}, 32'd0);
      @(negedge clk) chk("R10 irq on third edge", {31'd0, irq_out}, 32'd1);
      chk("R10 atn released", {31'd0, atn_out}, 32'd0);
      sw_read();
   endtask

   task automatic load_msgs(logic [7:0] a, logic [7:0] b, logic [7:0] c);
      push_fifo(a); push_fifo(b); push_fifo(c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 bus outs", {28'd0, bsy_out, sel_out, atn_out, ack_out}, 32'd0);
      chk("R1 irq", {20'd0, irq_out, irq_status, seq_step}, 32'd0);
      chk("R1 cmd_reg", {24'd0, cmd_reg}, 32'd0);

      // R2/R3 full sequence, 6 command bytes
      flush();
      load_msgs(8'hC0, 8'h20, 8'h05);
      for (int i = 0; i < 6; i++) push_fifo(8'h30 + 8'(i));
      expect_irq(8'h18, 3'b100, "R3 complete status");
      issue(8'h46, 6, 200);
      select_target();
      xfer(3'b110, 8'hC0, 1'b1, "R2 msg0");
      xfer(3'b110, 8'h20, 1'b1, "R2 msg1");
      xfer(3'b110, 8'h05, 1'b0, "R3 msg2");
      for (int i = 0; i < 6; i++) xfer(3'b010, 8'h30 + 8'(i), 1'b0, "R3 cdb");
      wait_irq();
      sw_read();
      chk("R2 cmd_reg", {24'd0, cmd_reg}, 32'h46);
      chk("R3 fifo drained", wp - rp, 32'd0);
      disconnect();

      // R4 selection timeout
      flush();
      expect_irq(8'h20, 3'b000, "R4 timeout status");
      issue(8'h46, 0, 30);
      wait_irq();
      chk("R4 sel/atn released", {30'd0, sel_out, atn_out}, 32'd0);
      sw_read();

      // R5 no message-out, then R9 legal ATN drop
      flush();
      load_msgs(8'hC1, 8'h21, 8'h06);
      expect_irq(8'h18, 3'b000, "R5 status");
      issue(8'h46, 2, 200);
      select_target();
      stop_phase(3'b001);
      chk("R5 atn held", {31'd0, atn_out}, 32'd1);
      sw_read();
      issue(8'h1B, 0, 0);
      chk("R9 atn dropped", {31'd0, atn_out}, 32'd0);
      chk("R9 cmd_reg", {24'd0, cmd_reg}, 32'h1B);
      chk("R9 no irq", {31'd0, irq_out}, 32'd0);
      disconnect();

      // R6 early exit after two message bytes
      flush();
      load_msgs(8'hC2, 8'h22, 8'h07);
      push_fifo(8'h99);
      expect_irq(8'h18, 3'b010, "R6 status");
      issue(8'h46, 1, 200);
      select_target();
      xfer(3'b110, 8'hC2, 1'b1, "R6 msg0");
      xfer(3'b110, 8'h22, 1'b1, "R6 msg1");
      stop_phase(3'b111);
      chk("R6 atn held", {31'd0, atn_out}, 32'd1);
      sw_read();
      disconnect();

      // R7 no command phase after third byte
      flush();
      load_msgs(8'hC3, 8'h23, 8'h08);
      push_fifo(8'h98);
      expect_irq(8'h18, 3'b010, "R7 status");
      issue(8'h46, 1, 200);
      select_target();
      xfer(3'b110, 8'hC3, 1'b1, "R7 msg0");
      xfer(3'b110, 8'h23, 1'b1, "R7 msg1");
      xfer(3'b110, 8'h08, 1'b0, "R7 msg2");
      stop_phase(3'b011);
      chk("R7 atn low", {31'd0, atn_out}, 32'd0);
      sw_read();
      disconnect();

      // R8 phase change mid-CDB
      flush();
      load_msgs(8'hC4, 8'h24, 8'h09);
      for (int i = 0; i < 5; i++) push_fifo(8'h50 + 8'(i));
      expect_irq(8'h18, 3'b011, "R8 status");
      issue(8'h46, 5, 200);
      select_target();
      xfer(3'b110, 8'hC4, 1'b1, "R8 msg0");
      xfer(3'b110, 8'h24, 1'b1, "R8 msg1");
      xfer(3'b110, 8'h09, 1'b0, "R8 msg2");
      xfer(3'b010, 8'h50, 1'b0, "R8 cdb0");
      xfer(3'b010, 8'h51, 1'b0, "R8 cdb1");
      stop_phase(3'b011);
      chk("R8 bytes left", wp - rp, 32'd3);
      sw_read();
      disconnect();

      // R9 illegal command, R11 hold and clear
      flush();
      expect_irq(8'h40, 3'b000, "R9 illegal status");
      issue(8'h12, 0, 0);
      wait_irq();
      chk("R9 cmd_reg cleared", {24'd0, cmd_reg}, 32'd0);
      chk("R9 bus idle", {30'd0, sel_out, bsy_out}, 32'd0);
      repeat (10) @(negedge clk);
      chk("R11 held", {23'd0, irq_out, irq_status}, 32'h140);
      sw_read();
      chk("R11 cleared", {20'd0, irq_out, irq_status, seq_step}, 32'd0);

      // R3 second pattern, one command byte
      flush();
      load_msgs(8'h80, 8'h21, 8'hAA);
      push_fifo(8'h5A);
      expect_irq(8'h18, 3'b100, "R3 complete status 2");
      issue(8'h46, 1, 100);
      select_target();
      xfer(3'b110, 8'h80, 1'b1, "R2 msg0 b");
      xfer(3'b110, 8'h21, 1'b1, "R2 msg1 b");
      xfer(3'b110, 8'hAA, 1'b0, "R3 msg2 b");
      xfer(3'b010, 8'h5A, 1'b0, "R3 cdb b");
      wait_irq();
      sw_read();
      disconnect();

      repeat (4) @(negedge clk);
      chk("R2 all bytes seen", exp_bytes.size(), 32'd0);
      chk("R11 all irqs seen", exp_irq.size(), 32'd0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule